// File: doc/BRIEF.md
# Registered Narrow-to-Wide Bus Exchanger

This block moves data in both directions between a narrow port A and a wide side made of two equal-width halves, 1B and 2B. Going from A to the wide side, two words that arrive on A one after the other can be presented at the same time as one double-width word: the 1B half has a two-register pipeline and the 2B half has a single register. Going from the wide side to A, each half is caught in its own register, and a select sampled on the clock chooses which of the two is driven onto A.

Each port is modelled as an input bus, an output bus and a drive-enable. The drive-enables follow two active-low output-enable controls that are sampled on the clock, so a change of bus direction lands on a clock edge. Every storage register has its own active-low load enable and keeps its value while that enable is high. A synchronous active-high reset clears the data and disables both ports.

Top module: `bus_exchanger`

## Requirements
- R1: A data register changes only on a rising clock edge where its own active-low enable is 0. While the enable is 1 the register, and the output it feeds, keeps its value.
- R2: The 1B path is two registers in series. The first loads `a_in` when `ld_a_lo_n` is 0. The second, which drives `b1_out`, loads the first register's contents when `ld_a_hi_n` is 0.
- R3: The 2B path is one register that loads `a_in` into `b2_out` when `ld_a_hi_n` is 0.
- R4: With `ld_a_lo_n` and `ld_a_hi_n` both 0, a word presented on `a_in` appears on `b1_out` after two rising edges.
- R5: A word loaded with `ld_a_lo_n`=0, `ld_a_hi_n`=1, followed by the next word with `ld_a_lo_n`=1, `ld_a_hi_n`=0, makes the first word appear on `b1_out` together with the second word on `b2_out`.
- R6: The 1B capture register loads `b1_in` when `ld_b1_n` is 0. The 2B capture register loads `b2_in` when `ld_b2_n` is 0.
- R7: `pick_b1` is sampled on the rising edge. Sampled as 1, `a_out` shows the 1B capture register. Sampled as 0, it shows the 2B capture register. A change of `pick_b1` has no effect on `a_out` before the next edge.
- R8: `oe_a_n` and `oe_b_n` are sampled on the rising edge. `a_drive` is 1 exactly when the last sampled `oe_a_n` was 0. `b_drive` is 1 exactly when the last sampled `oe_b_n` was 0. Neither output changes between edges.
- R9: A rising edge with `rst` high clears every data register to 0, which makes `a_out`, `b1_out` and `b2_out` equal to 0. It also sets the sampled select to 0 and both drive-enables to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| a_in | input | W | Narrow port, incoming data |
| a_out | output | W | Narrow port, outgoing data |
| a_drive | output | 1 | Narrow port drive-enable |
| b1_in | input | W | Wide low half, incoming data |
| b1_out | output | W | Wide low half, outgoing data |
| b2_in | input | W | Wide high half, incoming data |
| b2_out | output | W | Wide high half, outgoing data |
| b_drive | output | 1 | Drive-enable for both wide halves |
| ld_a_lo_n | input | 1 | Load enable of the first 1B-path stage, active low |
| ld_a_hi_n | input | 1 | Load enable of the second 1B-path stage and the 2B-path register, active low |
| ld_b1_n | input | 1 | Load enable of the 1B capture register, active low |
| ld_b2_n | input | 1 | Load enable of the 2B capture register, active low |
| pick_b1 | input | 1 | Return-path select, sampled on the clock |
| oe_a_n | input | 1 | Narrow port output enable, active low, sampled |
| oe_b_n | input | 1 | Wide side output enable, active low, sampled |

## Verification
The bench builds the block with the default width of 12. At that width, hand-written words such as 0x555 and 0xAAA make it easy to tell the two pipeline stages and the two capture registers apart. A table walks through the packing sequence, the two-edge latency and switching of the select. Directed steps then sample the select and output enables between edges, and a long stretch of random enables and data is compared against a cycle model written from the requirements.

// File: rtl/bus_exchanger.sv
`timescale 1ns/1ps
module bus_exchanger #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] a_in,
  output logic [W-1:0] a_out,
  output logic         a_drive,
  input  logic [W-1:0] b1_in,
  output logic [W-1:0] b1_out,
  input  logic [W-1:0] b2_in,
  output logic [W-1:0] b2_out,
  output logic         b_drive,
  input  logic         ld_a_lo_n,
  input  logic         ld_a_hi_n,
  input  logic         ld_b1_n,
  input  logic         ld_b2_n,
  input  logic         pick_b1,
  input  logic         oe_a_n,
  input  logic         oe_b_n
);

  logic [W-1:0] a_stage, b1_q, b2_q, cap1_q, cap2_q;
  logic         pick_q, oea_q, oeb_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      a_stage <= '0;
      b1_q    <= '0;
      b2_q    <= '0;
      cap1_q  <= '0;
      cap2_q  <= '0;
      pick_q  <= 1'b0;
      oea_q   <= 1'b1;
      oeb_q   <= 1'b1;
    end else begin
      if (!ld_a_lo_n) a_stage <= a_in;
      if (!ld_a_hi_n) begin
        b1_q <= a_stage;
        b2_q <= a_in;
      end
      if (!ld_b1_n) cap1_q <= b1_in;
      if (!ld_b2_n) cap2_q <= b2_in;
      pick_q <= pick_b1;
      oea_q  <= oe_a_n;
      oeb_q  <= oe_b_n;
    end
  end

  assign b1_out  = b1_q;
  assign b2_out  = b2_q;
  assign a_out   = pick_q ? cap1_q : cap2_q;
  assign a_drive = ~oea_q;
  assign b_drive = ~oeb_q;

  assert_hold_wide_R1: assert property (@(posedge clk) disable iff (rst)
    ld_a_hi_n |=> ($stable(b1_out) && $stable(b2_out)));

  assert_load_b2_R3: assert property (@(posedge clk) disable iff (rst)
    !ld_a_hi_n |=> (b2_out == $past(a_in)));

  assert_two_edges_R4: assert property (@(posedge clk) disable iff (rst)
    (!ld_a_lo_n ##1 !ld_a_hi_n) |=> (b1_out == $past(a_in, 2)));

  assert_pick_b2_R6: assert property (@(posedge clk) disable iff (rst)
    (!ld_b2_n && !pick_b1) |=> (a_out == $past(b2_in)));

  assert_pick_b1_R7: assert property (@(posedge clk) disable iff (rst)
    (!ld_b1_n && pick_b1) |=> (a_out == $past(b1_in)));

  assert_drive_sampled_R8: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((a_drive == !$past(oe_a_n)) && (b_drive == !$past(oe_b_n))));

endmodule

// File: tb/test_bus_exchanger.sv
`timescale 1ns/1ps
module test_bus_exchanger;
  localparam int W = 12;

  logic clk = 1'b0;
  logic rst;
  logic [W-1:0] a_in, b1_in, b2_in, a_out, b1_out, b2_out;
  logic a_drive, b_drive;
  logic ld_a_lo_n, ld_a_hi_n, ld_b1_n, ld_b2_n, pick_b1, oe_a_n, oe_b_n;

  always #5 clk = ~clk;

  bus_exchanger #(.W(W)) i_bus_exchanger (
    .clk(clk), .rst(rst),
    .a_in(a_in), .a_out(a_out), .a_drive(a_drive),
    .b1_in(b1_in), .b1_out(b1_out),
    .b2_in(b2_in), .b2_out(b2_out), .b_drive(b_drive),
    .ld_a_lo_n(ld_a_lo_n), .ld_a_hi_n(ld_a_hi_n),
    .ld_b1_n(ld_b1_n), .ld_b2_n(ld_b2_n),
    .pick_b1(pick_b1), .oe_a_n(oe_a_n), .oe_b_n(oe_b_n)
  );

  typedef struct packed {
    logic [11:0] a, b1, b2;
    logic ea1, ea2, eb1, eb2, sel, oea, oeb;
    logic [11:0] xb1, xb2, xa;
    logic xad, xbd;
  } vec_t;

  // expected values are the outputs after the edge that samples the vector
  localparam int NV = 10;
  localparam vec_t TBL [NV] = '{
    '{12'h111, 12'h000, 12'h000, 1'b0,1'b1,1'b1,1'b1,1'b0,1'b1,1'b0, 12'h000, 12'h000, 12'h000, 1'b0,1'b1},
    '{12'h222, 12'h000, 12'h000, 1'b1,1'b0,1'b1,1'b1,1'b0,1'b1,1'b0, 12'h111, 12'h222, 12'h000, 1'b0,1'b1},
    '{12'h333, 12'h000, 12'h000, 1'b0,1'b1,1'b1,1'b1,1'b0,1'b1,1'b0, 12'h111, 12'h222, 12'h000, 1'b0,1'b1},
    '{12'h444, 12'h000, 12'h000, 1'b1,1'b0,1'b1,1'b1,1'b0,1'b1,1'b0, 12'h333, 12'h444, 12'h000, 1'b0,1'b1},
    '{12'h555, 12'h000, 12'h000, 1'b0,1'b0,1'b1,1'b1,1'b0,1'b1,1'b0, 12'h333, 12'h555, 12'h000, 1'b0,1'b1},
    '{12'h666, 12'h000, 12'h000, 1'b0,1'b0,1'b1,1'b1,1'b0,1'b1,1'b0, 12'h555, 12'h666, 12'h000, 1'b0,1'b1},
    '{12'h777, 12'hAAA, 12'hBBB, 1'b1,1'b1,1'b0,1'b0,1'b1,1'b0,1'b1, 12'h555, 12'h666, 12'hAAA, 1'b1,1'b0},
    '{12'h777, 12'hCCC, 12'hBBB, 1'b1,1'b1,1'b1,1'b1,1'b0,1'b0,1'b1, 12'h555, 12'h666, 12'hBBB, 1'b1,1'b0},
    '{12'h777, 12'hCCC, 12'hBBB, 1'b1,1'b1,1'b1,1'b1,1'b1,1'b0,1'b1, 12'h555, 12'h666, 12'hAAA, 1'b1,1'b0},
    '{12'h777, 12'hCCC, 12'hDDD, 1'b1,1'b1,1'b1,1'b0,1'b0,1'b0,1'b1, 12'h555, 12'h666, 12'hDDD, 1'b1,1'b0}
  };

  int n_chk = 0;
  int n_bad = 0;
  logic finished = 1'b0;

  task automatic chk(input string req, input string what, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic idle_inputs();
    a_in = '0; b1_in = '0; b2_in = '0;
    ld_a_lo_n = 1'b1; ld_a_hi_n = 1'b1; ld_b1_n = 1'b1; ld_b2_n = 1'b1;
    pick_b1 = 1'b0; oe_a_n = 1'b1; oe_b_n = 1'b1;
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  // cycle model built from the requirements
  logic [W-1:0] m_st, m_b1, m_b2, m_c1, m_c2;
  logic m_pk, m_ad, m_bd;

  task automatic model_reset();
    m_st = '0; m_b1 = '0; m_b2 = '0; m_c1 = '0; m_c2 = '0;
    m_pk = 1'b0; m_ad = 1'b0; m_bd = 1'b0;
  endtask

  task automatic model_edge();
    if (!ld_a_hi_n) begin m_b1 = m_st; m_b2 = a_in; end
    if (!ld_a_lo_n) m_st = a_in;
    if (!ld_b1_n) m_c1 = b1_in;
    if (!ld_b2_n) m_c2 = b2_in;
    m_pk = pick_b1; m_ad = !oe_a_n; m_bd = !oe_b_n;
  endtask

  initial begin
    #1000000;
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    idle_inputs();
    rst = 1'b1;
    @(negedge clk);
    tick();
    rst = 1'b0;
    // R9: reset state
    chk("R9", "a_out", a_out, '0);
    chk("R9", "b1_out", b1_out, '0);
    chk("R9", "b2_out", b2_out, '0);
    chk("R9", "a_drive", {11'd0, a_drive}, '0);
    chk("R9", "b_drive", {11'd0, b_drive}, '0);

    // table: packing sequence (R5), two-edge path (R4), select (R7), capture (R6)
    for (int i = 0; i < NV; i++) begin
      a_in = TBL[i].a; b1_in = TBL[i].b1; b2_in = TBL[i].b2;
      ld_a_lo_n = TBL[i].ea1; ld_a_hi_n = TBL[i].ea2;
      ld_b1_n = TBL[i].eb1; ld_b2_n = TBL[i].eb2;
      pick_b1 = TBL[i].sel; oe_a_n = TBL[i].oea; oe_b_n = TBL[i].oeb;
      tick();
      chk("R2", $sformatf("vec %0d b1_out", i), b1_out, TBL[i].xb1);
      chk("R3", $sformatf("vec %0d b2_out", i), b2_out, TBL[i].xb2);
      chk("R7", $sformatf("vec %0d a_out", i), a_out, TBL[i].xa);
      chk("R8", $sformatf("vec %0d a_drive", i), {11'd0, a_drive}, {11'd0, TBL[i].xad});
      chk("R8", $sformatf("vec %0d b_drive", i), {11'd0, b_drive}, {11'd0, TBL[i].xbd});
    end

    // R5: explicit pair packing after a fresh reset
    idle_inputs(); rst = 1'b1; tick(); rst = 1'b0;
    a_in = 12'h0F1; ld_a_lo_n = 1'b0; tick();
    a_in = 12'h0F2; ld_a_lo_n = 1'b1; ld_a_hi_n = 1'b0; tick();
    chk("R5", "first word on b1", b1_out, 12'h0F1);
    chk("R5", "second word on b2", b2_out, 12'h0F2);

    // R4: with both enables low a word needs two edges to reach b1_out
    a_in = 12'h3C3; ld_a_lo_n = 1'b0; ld_a_hi_n = 1'b0; tick();
    chk("R4", "b1 after one edge", b1_out, 12'h0F1);
    a_in = 12'h5A5; tick();
    chk("R4", "b1 after two edges", b1_out, 12'h3C3);

    // R1: enables high, changing inputs leave all outputs alone
    ld_a_lo_n = 1'b1; ld_a_hi_n = 1'b1; ld_b1_n = 1'b0; ld_b2_n = 1'b0;
    b1_in = 12'h123; b2_in = 12'h456; pick_b1 = 1'b1; tick();
    ld_b1_n = 1'b1; ld_b2_n = 1'b1;
    for (int k = 0; k < 4; k++) begin
      a_in = 12'(k * 12'h101 + 12'h0E0); b1_in = ~a_in; b2_in = a_in ^ 12'hFFF;
      tick();
    end
    chk("R1", "b1 held", b1_out, 12'h3C3);
    chk("R1", "b2 held", b2_out, 12'h5A5);
    chk("R1", "a_out held (1B capture)", a_out, 12'h123);
    pick_b1 = 1'b0; tick();
    chk("R6", "2B capture held", a_out, 12'h456);

    // R7: select change does not act before the edge
    pick_b1 = 1'b1; #1;
    chk("R7", "a_out before edge", a_out, 12'h456);
    tick();
    chk("R7", "a_out after edge", a_out, 12'h123);

    // R8: output enable change does not act before the edge
    oe_a_n = 1'b0; oe_b_n = 1'b0; #1;
    chk("R8", "a_drive before edge", {11'd0, a_drive}, '0);
    chk("R8", "b_drive before edge", {11'd0, b_drive}, '0);
    tick();
    chk("R8", "a_drive after edge", {11'd0, a_drive}, 12'd1);
    chk("R8", "b_drive after edge", {11'd0, b_drive}, 12'd1);

    // R9: reset in mid-run clears everything
    rst = 1'b1; tick(); rst = 1'b0;
    chk("R9", "mid-run a_out", a_out, '0);
    chk("R9", "mid-run b1_out", b1_out, '0);
    chk("R9", "mid-run b2_out", b2_out, '0);
    chk("R9", "mid-run a_drive", {11'd0, a_drive}, '0);
    chk("R9", "mid-run b_drive", {11'd0, b_drive}, '0);

    // random run against the cycle model (R1 to R8)
    idle_inputs(); model_reset();
    for (int n = 0; n < 400; n++) begin
      a_in = W'($urandom); b1_in = W'($urandom); b2_in = W'($urandom);
      {ld_a_lo_n, ld_a_hi_n, ld_b1_n, ld_b2_n, pick_b1, oe_a_n, oe_b_n} = 7'($urandom);
      model_edge();
      tick();
      chk("R2", "random b1_out", b1_out, m_b1);
      chk("R3", "random b2_out", b2_out, m_b2);
      chk("R6", "random a_out", a_out, m_pk ? m_c1 : m_c2);
      chk("R8", "random drives", {10'd0, a_drive, b_drive}, {10'd0, m_ad, m_bd});
    end

    finished = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule